// File: doc/BRIEF.md
# Multi-format Audio Serial Transmitter

This block turns parallel audio sample words into a single serial data stream and drives the bit clock and frame clock itself, acting as the clock master. One shifting path serves four stereo layouts: I2S, left-justified, right-justified and a short-pulse DSP layout. It also serves two packed time-division layouts that carry four channels in 32-bit slots, in 128-bit and 256-bit frames. The layout and the word width are chosen at run time.

Four 24-bit words are presented in parallel: left 0, left 1, right 0 and right 1. The stereo layouts send left 0 and right 0 only. Once per frame the block raises `sample_take` for one system clock. In that cycle it captures the four words, the format code and the width code, and it uses them for the whole of the next frame. The stream has no back-pressure. The producer must hold valid words whenever `sample_take` is high, and the transmitter never waits for data. Values on the sample, format and width inputs at any other time have no effect.

Top module: `aud_tx_serializer`

## Requirements
- R1: During and right after reset, `bclk` is high, `lrclk` and `sdata` are low and `sample_take` is low. The first capture occurs on the first bit-clock fall after reset. The frame it starts carries the reset value zero in every bit until the captured words take effect.
- R2: `bclk` has a period of 2*BCLK_HALF system clocks. `sdata` and `lrclk` change only in the cycle in which `bclk` falls.
- R3: A frame is 64 bits for format codes 0 to 3 and for the reserved codes. It is 128 bits for code 5 and 256 bits for code 4. `sample_take` is high for exactly one clock per frame. It is raised on the fall that starts the last bit of the current frame.
- R4: Format 000 (I2S): `lrclk` is low for bits 0-31 (left 0) and high for bits 32-63 (right 0). The MSB is sent one bit after each `lrclk` edge.
- R5: Format 011 (left-justified): the same `lrclk` as R4, with the MSB on the first bit of each half.
- R6: Format 001 (right-justified): the same `lrclk` as R4. The data starts at bit 32 minus the width of each half, so the LSB falls on bit 31 of the half.
- R7: Format 010 (DSP): `lrclk` is high only on bit 0 of each 32-bit half, which gives two pulses per 64-bit frame. Left 0, then right 0, start with the MSB on bit 1 of their half.
- R8: Format 101 (128-bit frame): the 32-bit slots 0 to 3 carry left 0, left 1, right 0 and right 1, each MSB first from the slot's first bit. `lrclk` is low for the first 64 bits.
- R9: Format 100 (256-bit frame): slots 0, 1, 4 and 5 carry left 0, left 1, right 0 and right 1, MSB at slot start. Slots 2, 3, 6 and 7 send 0. `lrclk` is low for the first 128 bits.
- R10: Width code 00 sends 24 bits, 01 sends 20 bits, 10 sends 16 bits, and 11 is treated as 24. The bits sent are the top bits of each 24-bit word. Every bit position outside the data window sends 0.
- R11: Sample words, format and width are captured only in the `sample_take` cycle. Changes at any other time do not alter the frame in progress.
- R12: The reserved format codes 110 and 111 behave exactly as I2S.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| fmt_sel | input | 3 | Format code, captured at `sample_take` |
| width_sel | input | 2 | Word width code, captured at `sample_take` |
| smp_l0 | input | 24 | Left 0 sample word |
| smp_l1 | input | 24 | Left 1 sample word (packed formats only) |
| smp_r0 | input | 24 | Right 0 sample word |
| smp_r1 | input | 24 | Right 1 sample word (packed formats only) |
| bclk | output | 1 | Bit clock; the receiver samples on its rising edge |
| lrclk | output | 1 | Frame or channel clock |
| sdata | output | 1 | Serial data, MSB first |
| sample_take | output | 1 | One-clock strobe in which the inputs are captured |

## Verification
The bench builds the block with BCLK_HALF = 1, the fastest bit clock, one system clock per bit-clock phase. This keeps even the 256-bit frame short enough to sweep all eight format codes against all four width codes, two frames each. Every received bit and frame-clock level is compared with a bit-position calculation in the bench. The inputs are changed in the middle of frames, so that frame-boundary capture and the fall-edge-only output timing are exercised in every combination.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
  localparam int SAMPLE_W  = 24;
  localparam int SLOT_W    = 32;
  localparam int IDX_W     = 8;
  localparam int NUM_WORDS = 4;

  localparam logic [2:0] FMT_I2S   = 3'd0;
  localparam logic [2:0] FMT_RJ    = 3'd1;
  localparam logic [2:0] FMT_DSP   = 3'd2;
  localparam logic [2:0] FMT_LJ    = 3'd3;
  localparam logic [2:0] FMT_PK256 = 3'd4;
  localparam logic [2:0] FMT_PK128 = 3'd5;

  // reserved codes fall back to I2S
  function automatic logic [2:0] fmt_norm(input logic [2:0] f);
    return (f > FMT_PK128) ? FMT_I2S : f;
  endfunction

  function automatic logic [5:0] width_bits(input logic [1:0] w);
    case (w)
      2'd1:    return 6'd20;
      2'd2:    return 6'd16;
      default: return 6'd24;
    endcase
  endfunction

  function automatic logic [8:0] frame_bits(input logic [2:0] f);
    case (f)
      FMT_PK256: return 9'd256;
      FMT_PK128: return 9'd128;
      default:   return 9'd64;
    endcase
  endfunction
endpackage

// File: rtl/aud_tx_bclk_gen.sv
module aud_tx_bclk_gen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  output logic bclk,
  output logic fall_tick
);
  localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [DW-1:0] div_q;
  logic          tick;

  assign tick = !rst && (div_q == DW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      bclk  <= 1'b1;
    end else if (tick) begin
      div_q <= '0;
      bclk  <= ~bclk;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // high in the cycle whose closing edge drives bclk low
  assign fall_tick = tick & bclk;
endmodule

// File: rtl/aud_tx_sequencer.sv
module aud_tx_sequencer
  import aud_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             fall_tick,
  input  logic [2:0]       fmt_in,
  input  logic [1:0]       wsel_in,
  output logic             take,
  output logic [IDX_W-1:0] nxt_idx,
  output logic [2:0]       act_fmt,
  output logic [1:0]       act_wsel
);
  logic [IDX_W-1:0] idx_q;
  logic             last_q;
  logic [8:0]       cur_len;

  assign cur_len = frame_bits(act_fmt);
  assign take    = fall_tick && !last_q && ({1'b0, idx_q} == cur_len - 9'd2);
  assign nxt_idx = last_q ? '0 : idx_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= IDX_W'(62);
      last_q   <= 1'b0;
      act_fmt  <= FMT_I2S;
      act_wsel <= 2'd0;
    end else if (fall_tick) begin
      idx_q  <= nxt_idx;
      last_q <= take;
      if (take) begin
        act_fmt  <= fmt_norm(fmt_in);
        act_wsel <= wsel_in;
      end
    end
  end
endmodule

// File: rtl/aud_tx_bit_pick.sv
module aud_tx_bit_pick
  import aud_tx_pkg::*;
(
  input  logic [2:0]          fmt,
  input  logic [1:0]          wsel,
  input  logic [IDX_W-1:0]    idx,
  input  logic [SAMPLE_W-1:0] words [NUM_WORDS],
  output logic                bit_o,
  output logic                lr_o
);
  logic [4:0]          pos;
  logic [5:0]          off;
  logic [5:0]          wb;
  logic [5:0]          rel;
  logic [4:0]          bsel;
  logic [SAMPLE_W-1:0] word;
  logic                has;
  logic                in_win;

  assign pos = idx[4:0];
  assign wb  = width_bits(wsel);

  always_comb begin
    off  = 6'd1;
    has  = 1'b1;
    word = idx[5] ? words[2] : words[0];
    lr_o = idx[5];
    case (fmt)
      FMT_PK128: begin
        word = words[idx[6:5]];
        off  = 6'd0;
        lr_o = idx[6];
      end
      FMT_PK256: begin
        has  = !idx[6];
        word = words[{idx[7], idx[5]}];
        off  = 6'd0;
        lr_o = idx[7];
      end
      FMT_LJ:  off = 6'd0;
      FMT_RJ:  off = 6'(SLOT_W) - wb;
      FMT_DSP: lr_o = (pos == 5'd0);
      default: ;
    endcase
  end

  assign rel    = {1'b0, pos} - off;
  assign in_win = has && ({1'b0, pos} >= off) && (rel < wb);
  assign bsel   = 5'(SAMPLE_W - 1) - rel[4:0];
  assign bit_o  = in_win & word[bsel];
endmodule

// File: rtl/aud_tx_serializer.sv
module aud_tx_serializer
  import aud_tx_pkg::*;
#(
  parameter int BCLK_HALF = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          fmt_sel,
  input  logic [1:0]          width_sel,
  input  logic [SAMPLE_W-1:0] smp_l0,
  input  logic [SAMPLE_W-1:0] smp_l1,
  input  logic [SAMPLE_W-1:0] smp_r0,
  input  logic [SAMPLE_W-1:0] smp_r1,
  output logic                bclk,
  output logic                lrclk,
  output logic                sdata,
  output logic                sample_take
);
  logic                fall_tick;
  logic                take;
  logic [IDX_W-1:0]    nxt_idx;
  logic [2:0]          act_fmt;
  logic [1:0]          act_wsel;
  logic                pick_bit;
  logic                pick_lr;
  logic [SAMPLE_W-1:0] smp_in [NUM_WORDS];
  logic [SAMPLE_W-1:0] shadow [NUM_WORDS];

  assign smp_in[0] = smp_l0;
  assign smp_in[1] = smp_l1;
  assign smp_in[2] = smp_r0;
  assign smp_in[3] = smp_r1;

  aud_tx_bclk_gen #(.HALF(BCLK_HALF)) u_bclk (
    .clk      (clk),
    .rst      (rst),
    .bclk     (bclk),
    .fall_tick(fall_tick)
  );

  aud_tx_sequencer u_seq (
    .clk      (clk),
    .rst      (rst),
    .fall_tick(fall_tick),
    .fmt_in   (fmt_sel),
    .wsel_in  (width_sel),
    .take     (take),
    .nxt_idx  (nxt_idx),
    .act_fmt  (act_fmt),
    .act_wsel (act_wsel)
  );

  for (genvar c = 0; c < NUM_WORDS; c++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (rst)       shadow[c] <= '0;
      else if (take) shadow[c] <= smp_in[c];
    end
  end

  aud_tx_bit_pick u_pick (
    .fmt  (act_fmt),
    .wsel (act_wsel),
    .idx  (nxt_idx),
    .words(shadow),
    .bit_o(pick_bit),
    .lr_o (pick_lr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lrclk <= 1'b0;
      sdata <= 1'b0;
    end else if (fall_tick) begin
      lrclk <= pick_lr;
      sdata <= pick_bit;
    end
  end

  assign sample_take = take;
endmodule

// File: rtl/aud_tx_serializer_chk.sv
module aud_tx_serializer_chk
  import aud_tx_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       bclk,
  input logic       lrclk,
  input logic       sdata,
  input logic       sample_take,
  input logic [2:0] act_fmt
);
  logic       bclk_q;
  logic       seen_q;
  logic [8:0] falls_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q  <= 1'b1;
      seen_q  <= 1'b0;
      falls_q <= '0;
    end else begin
      bclk_q <= bclk;
      if (sample_take) begin
        seen_q  <= 1'b1;
        falls_q <= '0;
      end else if (bclk_q && !bclk) begin
        falls_q <= falls_q + 1'b1;
      end
    end
  end

  AST_SDATA_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata) |-> $fell(bclk)); // R2
  AST_LRCLK_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(lrclk) |-> $fell(bclk)); // R2
  AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sample_take |=> !sample_take); // R3
  AST_TAKE_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    sample_take |=> $fell(bclk)); // R3
  AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (rst)
    (sample_take && seen_q) |-> (falls_q == frame_bits(act_fmt))); // R3
endmodule

bind aud_tx_serializer aud_tx_serializer_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .bclk       (bclk),
  .lrclk      (lrclk),
  .sdata      (sdata),
  .sample_take(sample_take),
  .act_fmt    (act_fmt)
);

// File: tb/aud_tx_serializer_tb_top.sv
`timescale 1ns/1ps
module aud_tx_serializer_tb_top;
  localparam int HALF = 1;

  typedef struct {
    int          raw;
    int          f;
    int          wb;
    logic [23:0] wd [4];
  } snap_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  fmt_sel = 3'd0;
  logic [1:0]  width_sel = 2'd0;
  logic [23:0] smp_l0 = 24'h0, smp_l1 = 24'h0, smp_r0 = 24'h0, smp_r1 = 24'h0;
  logic        bclk, lrclk, sdata, sample_take;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int strobes = 0;

  always #5 clk = ~clk;

  aud_tx_serializer #(.BCLK_HALF(HALF)) dut_i (
    .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .width_sel(width_sel),
    .smp_l0(smp_l0), .smp_l1(smp_l1), .smp_r0(smp_r0), .smp_r1(smp_r1),
    .bclk(bclk), .lrclk(lrclk), .sdata(sdata), .sample_take(sample_take)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int flen(input int f);
    return (f == 4) ? 256 : (f == 5) ? 128 : 64;
  endfunction

  function automatic bit exp_bit(input snap_t s, input int i);
    int pos = i % 32;
    int slot = i / 32;
    int off = 0;
    int k;
    if (s.f == 5) k = slot;
    else if (s.f == 4) k = (slot == 0) ? 0 : (slot == 1) ? 1 : (slot == 4) ? 2 : (slot == 5) ? 3 : -1;
    else begin
      k = (slot == 0) ? 0 : 2;
      off = (s.f == 1) ? 32 - s.wb : (s.f == 3) ? 0 : 1;
    end
    if (k < 0) return 1'b0;
    if (pos < off || pos - off >= s.wb) return 1'b0;
    return s.wd[k][23 - (pos - off)];
  endfunction

  function automatic bit exp_lr(input int f, input int i);
    if (f == 5) return (i / 64) != 0;
    if (f == 4) return (i / 128) != 0;
    if (f == 2) return (i % 32) == 0;
    return (i / 32) != 0;
  endfunction

  function automatic string tag(input snap_t s);
    string t;
    if (s.raw > 5) t = "R12";
    else case (s.f)
      0: t = "R4";
      1: t = "R6";
      2: t = "R7";
      3: t = "R5";
      4: t = "R9";
      default: t = "R8";
    endcase
    return {t, " R10 R11"};
  endfunction

  // monitor
  snap_t cur, nxt;
  int    idx = 63;
  int    since_rise = 0;
  bit    seen_rise = 0;
  logic  prev_bclk = 1'b1, prev_sd = 1'b0, prev_lr = 1'b0, prev_take = 1'b0;

  initial begin
    cur.raw = 0; cur.f = 0; cur.wb = 24;
    for (int k = 0; k < 4; k++) cur.wd[k] = 24'h0;
    nxt = cur;
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      since_rise++;
      if (sdata !== prev_sd || lrclk !== prev_lr)
        check(prev_bclk == 1'b1 && bclk == 1'b0, "R2 output change off bclk fall", bclk, 0);
      if (!prev_bclk && bclk) begin
        if (seen_rise) check(since_rise == 2 * HALF, "R2 bclk period", since_rise, 2 * HALF);
        seen_rise = 1;
        since_rise = 0;
        check(sdata == exp_bit(cur, idx), {tag(cur), " sdata"}, sdata, exp_bit(cur, idx));
        check(lrclk == exp_lr(cur.f, idx), {tag(cur), " lrclk"}, lrclk, exp_lr(cur.f, idx));
        idx++;
        if (idx == flen(cur.f)) begin
          idx = 0;
          cur = nxt;
        end
      end
      if (sample_take) begin
        check(!prev_take, "R3 strobe width", 2, 1);
        check(idx == flen(cur.f) - 1, "R3 strobe position", idx, flen(cur.f) - 1);
        nxt.raw = int'(fmt_sel);
        nxt.f   = (fmt_sel > 3'd5) ? 0 : int'(fmt_sel);
        nxt.wb  = (width_sel == 2'd1) ? 20 : (width_sel == 2'd2) ? 16 : 24;
        nxt.wd[0] = smp_l0; nxt.wd[1] = smp_l1; nxt.wd[2] = smp_r0; nxt.wd[3] = smp_r1;
        strobes++;
      end
    end
    prev_take = sample_take;
    prev_bclk = bclk;
    prev_sd   = sdata;
    prev_lr   = lrclk;
  end

  task automatic new_samples();
    smp_l0 = 24'($urandom); smp_l1 = 24'($urandom);
    smp_r0 = 24'($urandom); smp_r1 = 24'($urandom);
  endtask

  task automatic wait_strobe();
    int s0 = strobes;
    wait (strobes > s0);
    @(posedge clk); #2;
  endtask

  initial begin
    new_samples();
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(bclk == 1'b1, "R1 bclk in reset", bclk, 1);
    check(lrclk == 1'b0, "R1 lrclk in reset", lrclk, 0);
    check(sdata == 1'b0, "R1 sdata in reset", sdata, 0);
    check(sample_take == 1'b0, "R1 strobe in reset", sample_take, 0);
    @(posedge clk); #2;
    rst = 1'b0;
    for (int m = 0; m < 8; m++) begin
      for (int w = 0; w < 4; w++) begin
        wait_strobe();
        repeat (7) @(posedge clk); #2;
        fmt_sel = 3'(m);
        width_sel = 2'(w);
        new_samples();
        wait_strobe();
        repeat (11) @(posedge clk); #2;
        new_samples();
        wait_strobe();
      end
    end
    wait_strobe();
    wait_strobe();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", strobes, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule